// File: doc/BRIEF.md
# Rate-Throttled Pseudo-Random Test Word Source

This block feeds a built-in self test of a serial link. While its enable is high it offers 64-bit pseudo-random test words on a valid/ready stream. A 6-bit rate word sets the share of clock cycles that earn a word: exactly (rate + 1) out of every 64 cycles. The link can therefore be loaded at ((rate + 1) / 64) × 64 × f_clk bits per second. The payload is a maximal-length 31-bit sequence (polynomial x^31 + x^28 + 1). Each accepted word moves the sequence on by 64 bits, so a separate checker can lock onto it and compare what comes back. Every offered word also carries a timestamp: the value of a free-running cycle counter at the moment the word was first offered. The checker subtracts it from its own time to get the round-trip latency.

A fractional accumulator meters the pace. Each running cycle it adds rate + 1 to a 6-bit sum, and every overflow adds one credit to a small saturating counter. The block offers a word whenever it holds credit. A handshake spends one credit and advances the sequence. When the enable drops, a word that is already on offer is held until it is accepted. After that the stream goes quiet, so data in flight can drain to the checker. When the enable rises again, the sequence restarts from its fixed seed.

The control is a three-state machine. `GEN_IDLE` offers nothing. It takes the *start* transition to `GEN_RUN` when the enable is high, and that transition reseeds the sequence and clears the accumulator and credit. `GEN_RUN` earns credit and offers words. When the enable drops it takes *stop* back to `GEN_IDLE` if no word is left waiting, or *drain* to `GEN_FINISH` if the word on offer has not been accepted. `GEN_FINISH` keeps that one word on offer and takes *done* to `GEN_IDLE` on its handshake.

Top module: `prbs_rate_gen`

## Requirements
- R1: After reset, `out_valid` is low and `out_stamp` is 0.
- R2: While the block is idle and `gen_en` is low, `out_valid` stays low whatever `out_ready` does.
- R3: With `out_ready` held high, the number of words accepted in the first N cycles after the start transition is floor((N − 1) × (rate + 1) / 64). The first of those cycles never offers a word.
- R4: Rate word 63 gives an accepted word on every cycle after the first running cycle while `out_ready` is high.
- R5: With `out_ready` held high and a fixed rate, the gap in cycles between consecutive accepted words is always floor(64 / (rate + 1)) or ceil(64 / (rate + 1)).
- R6: `out_data` holds the next 64 output bits of the sequence s ← {s[29:0], s[30] ^ s[27]}. The first bit generated is placed at bit 63. The next word continues the sequence from where the last one stopped.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_stamp` hold their values into the next cycle. The sequence advances only on a handshake.
- R8: Credit earned while `out_ready` is low is kept, up to 7 words. After a long stall at rate 63 followed by a switch to rate 0, exactly 7 words are accepted back to back.
- R9: When `gen_en` falls while a word is on offer and not accepted, that word stays valid until it is accepted, and no further word follows. If nothing is pending, `out_valid` is low from the next cycle.
- R10: Each start transition reseeds the sequence with 31'h12345678, so the first word after every enable is the same.
- R11: `out_stamp` equals the number of clock cycles since reset (modulo 2^16) in the first cycle a word is offered, and it holds that value until the word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable |
| rate_word | input | 6 | Pace: (rate_word + 1) words per 64 cycles |
| out_ready | input | 1 | Downstream accepts the word on offer |
| out_valid | output | 1 | A test word is on offer |
| out_data | output | 64 | Pseudo-random test word |
| out_stamp | output | 16 | Cycle count at which the word was first offered |

## Verification
The embedded properties check the per-cycle invariants on every cycle:
- a stalled word, with its stamp, holds steady;
- the generator stays silent while disabled and idle;
- the sequence register never reaches the all-zero lock state and moves only on a handshake;
- the credit counter saturates rather than wrapping;
- the timestamp counter steps by one.

The exact pacing, the evenness of the gaps, the bit order of the sequence, the burst after a stall, draining on disable and reseeding on re-enable depend on histories of many cycles. Only the bench scenarios show these, by comparing against a cycle model built from the requirements under directed and random enable, ready and rate patterns.

// File: rtl/prbs_rate_gen_pkg.sv
package prbs_rate_gen_pkg;

    // Sequence register width and its two feedback taps (x^31 + x^28 + 1)
    localparam int PRBS_W = 31;
    localparam int TAP_HI = 30;
    localparam int TAP_LO = 27;

    typedef enum logic [1:0] {
        GEN_IDLE   = 2'd0,
        GEN_RUN    = 2'd1,
        GEN_FINISH = 2'd2
    } gen_state_t;

endpackage

// File: rtl/prbs_rate_credit.sv
module prbs_rate_credit #(
    parameter int RATE_W   = 6,
    parameter int CREDIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic              take,
    output logic              has_credit
);

    localparam logic [CREDIT_W-1:0] CMAX = '1;

    logic [RATE_W-1:0]   acc_q;
    logic [CREDIT_W-1:0] credit_q;
    logic [RATE_W:0]     acc_sum;
    logic                carry;
    logic                spend;
    logic [CREDIT_W:0]   credit_sum;

    assign has_credit = (credit_q != '0);

    always_comb begin
        acc_sum    = {1'b0, acc_q} + {1'b0, rate} + (RATE_W+1)'(1);
        carry      = run & acc_sum[RATE_W];
        spend      = take & has_credit;
        credit_sum = {1'b0, credit_q} + {{CREDIT_W{1'b0}}, carry}
                   - {{CREDIT_W{1'b0}}, spend};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            credit_q <= '0;
        end else if (clear) begin
            acc_q    <= '0;
            credit_q <= '0;
        end else begin
            if (run) begin
                acc_q <= acc_sum[RATE_W-1:0];
            end
            if (credit_sum > {1'b0, CMAX}) begin
                credit_q <= CMAX;
            end else begin
                credit_q <= credit_sum[CREDIT_W-1:0];
            end
        end
    end

    // R8: a full credit store saturates instead of wrapping to zero
    assert_credit_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && credit_q == CMAX && !take) |=> (credit_q == CMAX));

    // R3: an overflow with no spend adds exactly one credit
    assert_credit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && carry && !take && credit_q != CMAX)
        |=> (credit_q == CREDIT_W'($past(credit_q) + 1'b1)));

endmodule

// File: rtl/prbs_rate_lfsr.sv
module prbs_rate_lfsr
    import prbs_rate_gen_pkg::*;
#(
    parameter int                DATA_W = 64,
    parameter logic [PRBS_W-1:0] SEED   = 31'h12345678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);

    logic [PRBS_W-1:0] state_q;
    logic [PRBS_W-1:0] walk;
    logic [PRBS_W-1:0] state_after;
    logic              fb;

    // Unroll DATA_W steps: first bit produced lands in the MSB
    always_comb begin
        walk = state_q;
        word = '0;
        fb   = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            fb                 = walk[TAP_HI] ^ walk[TAP_LO];
            word[DATA_W-1-i]   = fb;
            walk               = {walk[PRBS_W-2:0], fb};
        end
        state_after = walk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= state_after;
        end
    end

    // R6: the sequence register never falls into the all-zero lock state
    assert_lock_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R7: the sequence moves only on a handshake or a reseed
    assert_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(state_q));

endmodule

// File: rtl/prbs_rate_stamp.sv
module prbs_rate_stamp #(
    parameter int STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               offer_valid,
    input  logic               offer_ready,
    output logic [STAMP_W-1:0] stamp
);

    logic [STAMP_W-1:0] time_q;
    logic [STAMP_W-1:0] stamp_q;
    logic               held_q;

    // A word offered for the first time takes the current time
    assign stamp = held_q ? stamp_q : time_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q  <= '0;
            stamp_q <= '0;
            held_q  <= 1'b0;
        end else begin
            time_q  <= time_q + 1'b1;
            stamp_q <= stamp;
            held_q  <= offer_valid & ~offer_ready;
        end
    end

    // R11: the time base advances by one every cycle
    assert_time_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (time_q == STAMP_W'($past(time_q) + 1'b1)));

    // R11: a stalled word keeps its stamp
    assert_stamp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !offer_ready) |=> (stamp == $past(stamp)));

endmodule

// File: rtl/prbs_rate_gen.sv
module prbs_rate_gen
    import prbs_rate_gen_pkg::*;
#(
    parameter int                DATA_W   = 64,
    parameter int                RATE_W   = 6,
    parameter int                STAMP_W  = 16,
    parameter int                CREDIT_W = 3,
    parameter logic [PRBS_W-1:0] SEED     = 31'h12345678
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_en,
    input  logic [RATE_W-1:0]  rate_word,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic [STAMP_W-1:0] out_stamp
);

    gen_state_t state_q;
    gen_state_t state_d;

    logic has_credit;
    logic fire;
    logic seed_load;
    logic acc_clear;
    logic acc_run;
    logic credit_take;

    assign fire = out_valid & out_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, stop, drain, done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: begin
                if (gen_en) state_d = GEN_RUN;
            end
            GEN_RUN: begin
                if (!gen_en) begin
                    if (out_valid && !out_ready) state_d = GEN_FINISH;
                    else                         state_d = GEN_IDLE;
                end
            end
            GEN_FINISH: begin
                if (fire) state_d = GEN_IDLE;
            end
            default: state_d = GEN_IDLE;
        endcase
    end

    // Per-state outputs
    always_comb begin
        out_valid   = 1'b0;
        seed_load   = 1'b0;
        acc_clear   = 1'b0;
        acc_run     = 1'b0;
        credit_take = 1'b0;
        unique case (state_q)
            GEN_IDLE: begin
                seed_load = gen_en;
                acc_clear = gen_en;
            end
            GEN_RUN: begin
                out_valid   = has_credit;
                acc_run     = gen_en;
                credit_take = out_ready;
            end
            GEN_FINISH: begin
                out_valid = 1'b1;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    prbs_rate_credit #(
        .RATE_W   (RATE_W),
        .CREDIT_W (CREDIT_W)
    ) credit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (acc_clear),
        .run        (acc_run),
        .rate       (rate_word),
        .take       (credit_take),
        .has_credit (has_credit)
    );

    prbs_rate_lfsr #(
        .DATA_W (DATA_W),
        .SEED   (SEED)
    ) lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load),
        .advance (fire),
        .word    (out_data)
    );

    prbs_rate_stamp #(
        .STAMP_W (STAMP_W)
    ) stamp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .offer_valid (out_valid),
        .offer_ready (out_ready),
        .stamp       (out_stamp)
    );

    // R7: a stalled word stays on offer with the same payload
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2: disabled and silent stays silent
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !out_valid) |=> !out_valid);

    // R9: after a drained word is taken with the enable low, nothing follows
    assert_drain_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && fire && state_q == GEN_FINISH) |=> !out_valid);

endmodule

// File: tb/prbs_rate_gen_tb.sv
module prbs_rate_gen_tb_top;

    localparam int DATA_W = 64;
    localparam int RATE_W = 6;
    localparam int STAMP_W = 16;
    localparam int CMAX = 7;
    localparam logic [30:0] SEED = 31'h12345678;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic               gen_en;
    logic [RATE_W-1:0]  rate_word;
    logic               out_ready;
    logic               out_valid;
    logic [DATA_W-1:0]  out_data;
    logic [STAMP_W-1:0] out_stamp;

    prbs_rate_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .rate_word (rate_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_stamp (out_stamp)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R2";

    // reference model, built from the requirements
    int                 m_st = 0;      // 0 idle, 1 run, 2 finish
    int                 m_acc = 0;
    int                 m_credit = 0;
    logic [30:0]        m_lfsr = SEED;
    logic [STAMP_W-1:0] m_time = '0;
    logic [STAMP_W-1:0] m_stamp = '0;
    bit                 m_held = 0;
    bit                 last_fire = 0;

    function automatic logic [63:0] seq_word(input logic [30:0] s);
        logic [63:0] w;
        logic b;
        for (int i = 0; i < 64; i++) begin
            b = s[30] ^ s[27];
            w[63-i] = b;
            s = {s[29:0], b};
        end
        return w;
    endfunction

    function automatic logic [30:0] seq_next(input logic [30:0] s);
        logic b;
        for (int i = 0; i < 64; i++) begin
            b = s[30] ^ s[27];
            s = {s[29:0], b};
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare current outputs, drive the inputs for the coming edge, step the model
    task automatic body(input bit en, input bit rdy, input logic [RATE_W-1:0] r);
        bit exp_valid;
        logic [STAMP_W-1:0] exp_stamp;
        bit fire;
        int sum;
        #1;
        exp_valid = (m_st == 1 && m_credit != 0) || m_st == 2;
        exp_stamp = m_held ? m_stamp : m_time;
        check(out_valid === exp_valid, cur_tag, "valid", 64'(out_valid), 64'(exp_valid));
        if (exp_valid) begin
            check(out_data === seq_word(m_lfsr), "R6", "data", out_data, seq_word(m_lfsr));
            check(out_stamp === exp_stamp, "R11", "stamp", 64'(out_stamp), 64'(exp_stamp));
        end
        gen_en = en; out_ready = rdy; rate_word = r;
        fire = exp_valid && rdy;
        last_fire = fire;
        m_held = exp_valid && !rdy;
        m_stamp = exp_stamp;
        m_time = m_time + 1'b1;
        case (m_st)
            0: if (en) begin m_st = 1; m_acc = 0; m_credit = 0; m_lfsr = SEED; end
            1: begin
                if (fire) m_lfsr = seq_next(m_lfsr);
                if (!en) begin
                    m_st = (exp_valid && !rdy) ? 2 : 0;
                end else begin
                    sum = m_acc + int'(r) + 1;
                    m_acc = sum % 64;
                    m_credit = m_credit + sum / 64 - (fire ? 1 : 0);
                    if (m_credit > CMAX) m_credit = CMAX;
                end
            end
            default: if (fire) begin m_lfsr = seq_next(m_lfsr); m_st = 0; end
        endcase
    endtask

    task automatic tick(input bit en, input bit rdy, input logic [RATE_W-1:0] r);
        @(negedge clk);
        body(en, rdy, r);
    endtask

    initial begin
        int fires;
        int last_idx;
        int lo;
        int hi;
        int rates[6];
        logic [63:0] held_data;
        void'($urandom(32'd4242));
        rst_n = 0; gen_en = 0; out_ready = 0; rate_word = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1", "valid after reset", 64'(out_valid), 64'd0);
        check(out_stamp === '0, "R1", "stamp after reset", 64'(out_stamp), 64'd0);
        rst_n = 1;
        cur_tag = "R1";
        body(0, 0, 0);

        // R2: idle, random ready
        cur_tag = "R2";
        for (int i = 0; i < 12; i++) tick(0, 1'($urandom % 2), 6'($urandom));

        // R4: full rate
        cur_tag = "R4";
        tick(1, 1, 63);
        fires = 0;
        for (int i = 0; i < 20; i++) begin tick(1, 1, 63); fires += last_fire; end
        check(fires == 19, "R4", "lines at full rate", 64'(fires), 64'd19);

        // R9: disable with nothing pending
        cur_tag = "R9";
        tick(0, 1, 63);
        tick(0, 1, 63);
        check(out_valid === 1'b0, "R9", "quiet after stop", 64'(out_valid), 64'd0);

        // R3 / R5: pacing and spacing at several rates
        rates = '{0, 1, 20, 31, 47, 0};
        rates[5] = int'($urandom % 64);
        foreach (rates[k]) begin
            cur_tag = "R3";
            tick(1, 1, 6'(rates[k]));
            fires = 0; last_idx = -1;
            lo = 64 / (rates[k] + 1);
            hi = (64 + rates[k]) / (rates[k] + 1);
            for (int i = 0; i < 200; i++) begin
                tick(1, 1, 6'(rates[k]));
                if (last_fire) begin
                    if (last_idx >= 0)
                        check((i - last_idx) == lo || (i - last_idx) == hi, "R5",
                              "gap", 64'(i - last_idx), 64'(lo));
                    last_idx = i;
                    fires++;
                end
            end
            check(fires == (199 * (rates[k] + 1)) / 64, "R3", "line count",
                  64'(fires), 64'((199 * (rates[k] + 1)) / 64));
            tick(0, 1, 0);
            tick(0, 1, 0);
        end

        // R7 / R8: stall then burst
        cur_tag = "R7";
        tick(1, 1, 63);
        tick(1, 0, 63);
        @(negedge clk); #1;
        held_data = out_data;
        body(1, 0, 63);
        for (int i = 0; i < 12; i++) begin
            tick(1, 0, 63);
            check(out_valid === 1'b1 && out_data === held_data, "R7", "stalled word",
                  out_data, held_data);
        end
        cur_tag = "R8";
        fires = 0;
        for (int i = 0; i < 8; i++) begin tick(1, 1, 0); fires += last_fire; end
        check(fires == CMAX, "R8", "burst after stall", 64'(fires), 64'(CMAX));

        // R9: disable with a word pending
        cur_tag = "R9";
        tick(1, 1, 63);
        tick(1, 1, 63);
        tick(1, 0, 63);
        tick(0, 0, 63);
        for (int i = 0; i < 3; i++) begin
            tick(0, 0, 63);
            check(out_valid === 1'b1, "R9", "pending kept", 64'(out_valid), 64'd1);
        end
        tick(0, 1, 63);
        tick(0, 1, 63);
        check(out_valid === 1'b0, "R9", "no word after drain", 64'(out_valid), 64'd0);

        // R10: reseed on re-enable
        cur_tag = "R10";
        tick(1, 1, 63);
        tick(1, 1, 63);
        tick(1, 1, 63);
        check(out_data === seq_word(SEED), "R10", "first word after enable",
              out_data, seq_word(SEED));
        tick(0, 1, 0);

        // random mix
        cur_tag = "R3";
        begin
            logic [RATE_W-1:0] r = 6'($urandom);
            for (int i = 0; i < 3000; i++) begin
                if ($urandom % 50 == 0) r = 6'($urandom);
                tick(1'($urandom % 16 != 0), 1'($urandom % 4 != 0), r);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule